// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This block conditions a small set of external interrupt pins before they reach an interrupt controller. Every pin is brought into the clock domain through a two-stage synchroniser. It is then judged against its own trigger mode, which can be rising edge, falling edge, either edge, active-high level or active-low level. The result is one request line per pin, and each line goes to one input of the downstream controller.

In edge modes a detected transition latches a pending bit, which stays set until software clears it. In level modes the request tracks the synchronised pin directly. A per-pin enable gates what reaches the request output. The pending bit still latches while its pin is disabled, so software clears it before it enables the pin.

A simple register port exposes four word locations: a mode word, a snapshot of the synchronised pin levels, a pending/clear word and an enable word. Reads are combinational from the current address. Writes take effect at the clock edge.

Top module: `xtu_top`

## Requirements
- R1: Offset 0x4 reads the synchronised pin levels, with bit i for pin i. A pin change driven before clock edge k is visible there after edge k+1 and not before.
- R2: Offset 0x0 holds one 3-bit mode field per pin, with pin i at bits [4i+2:4i]. Bit 4i+3 and all bits above the last field read as 0, and whatever is written to them is discarded.
- R3: After reset every mode field holds 6 (low level), so offset 0x0 reads 0x00666666. Enable, pending and every request output are 0.
- R4: Mode 1 (rising): a 0-to-1 transition of the synchronised pin sets pin i's pending bit, and a 1-to-0 transition does not. The pending bit appears on the request three clock edges after the pin change.
- R5: Mode 2 (falling): a 1-to-0 transition sets the pending bit, and a 0-to-1 transition does not.
- R6: Mode 3 (both edges): either transition sets the pending bit.
- R7: Mode 5 (high level): the request equals the synchronised pin level, and the pending bit never sets.
- R8: Mode 6 (low level): the request equals the inverse of the synchronised pin level, and the pending bit never sets.
- R9: Modes 0, 4 and 7 give no request and never set the pending bit.
- R10: Offset 0xC bit i enables pin i. With the bit clear the request is 0, but edge events still set the pending bit. Setting the enable later makes a latched pending bit visible on the request in the same cycle the write commits.
- R11: Offset 0x8 reads the pending bits. Writing there clears pin i's pending bit when data bit i is 0 and leaves it unchanged when data bit i is 1.
- R12: If an edge event and a clear of the same pin fall in the same clock, the pending bit ends up set.
- R13: Writes to offset 0x4 or to any unmapped address change no state. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | N_SRC | Raw external interrupt pins, asynchronous |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i (combinational) |
| irq_req_o | output | N_SRC | Per-pin request to the interrupt controller |

## Verification
The hardest case to reach from the ports is a clear write that commits in the same clock as a newly detected edge, because the edge only becomes visible internally after two synchroniser stages and one edge-detect stage. The stimulus toggles the pin on a falling clock edge. It then counts two rising edges and raises the clear write so that the write commits on the third rising edge, which is the one where the edge is registered. A table of mode, enable and pin-transition vectors covers each trigger code on a rotating pin. Directed sequences cover the rest: reset values, field packing, selective clear, late enable and ignored writes.

// File: rtl/xtu_pkg.sv
package xtu_pkg;

    localparam int unsigned XTU_MAX_SRC = 6;
    localparam int unsigned XTU_PITCH   = 4;
    localparam int unsigned XTU_MODE_W  = 3;

    typedef enum logic [XTU_MODE_W-1:0] {
        TRIG_OFF  = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_BOTH = 3'd3,
        TRIG_RSV4 = 3'd4,
        TRIG_HIGH = 3'd5,
        TRIG_LOW  = 3'd6,
        TRIG_RSV7 = 3'd7
    } trig_mode_e;

    localparam logic [3:0] OFS_MODE = 4'h0;
    localparam logic [3:0] OFS_CAP  = 4'h4;
    localparam logic [3:0] OFS_PEND = 4'h8;
    localparam logic [3:0] OFS_EN   = 4'hC;

    function automatic logic mode_is_edge(trig_mode_e m);
        return (m == TRIG_RISE) || (m == TRIG_FALL) || (m == TRIG_BOTH);
    endfunction

endpackage

// File: rtl/xtu_sync.sv
module xtu_sync #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    typedef struct packed {
        logic [WIDTH-1:0] st1;
        logic [WIDTH-1:0] st2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.st1 = d_i;
        sync_d.st2 = sync_q.st1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign q_o = sync_q.st2;

endmodule

// File: rtl/xtu_regs.sv
module xtu_regs
    import xtu_pkg::*;
#(
    parameter int unsigned N_SRC  = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    input  logic [N_SRC-1:0]             lvl_i,
    input  logic [N_SRC-1:0]             pend_i,
    output logic [DATA_W-1:0]            rdata_o,
    output trig_mode_e [N_SRC-1:0]       mode_o,
    output logic [N_SRC-1:0]             en_o,
    output logic [N_SRC-1:0]             clr_o
);

    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(OFS_CAP);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);

    typedef struct packed {
        trig_mode_e [N_SRC-1:0] mode;
        logic [N_SRC-1:0]       en;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [N_SRC-1:0]  clr_d;
    logic [DATA_W-1:0] rdata_d;

    always_comb begin
        regs_d  = regs_q;
        clr_d   = '0;
        rdata_d = '0;
        if (wr_i) begin
            if (addr_i == A_MODE) begin
                for (int i = 0; i < int'(N_SRC); i++) begin
                    regs_d.mode[i] = trig_mode_e'(wdata_i[XTU_PITCH*i +: XTU_MODE_W]);
                end
            end else if (addr_i == A_EN) begin
                regs_d.en = wdata_i[N_SRC-1:0];
            end else if (addr_i == A_PEND) begin
                clr_d = ~wdata_i[N_SRC-1:0];
            end
        end
        if (addr_i == A_MODE) begin
            for (int i = 0; i < int'(N_SRC); i++) begin
                rdata_d[XTU_PITCH*i +: XTU_MODE_W] = regs_q.mode[i];
            end
        end else if (addr_i == A_CAP) begin
            rdata_d[N_SRC-1:0] = lvl_i;
        end else if (addr_i == A_PEND) begin
            rdata_d[N_SRC-1:0] = pend_i;
        end else if (addr_i == A_EN) begin
            rdata_d[N_SRC-1:0] = regs_q.en;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < int'(N_SRC); i++) regs_q.mode[i] <= TRIG_LOW;
            regs_q.en <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mode_o  = regs_q.mode;
    assign en_o    = regs_q.en;
    assign clr_o   = clr_d;
    assign rdata_o = rdata_d;

    // R13: writes outside the mode and enable words leave stored state alone
    assert_no_stray_write_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i != A_MODE && addr_i != A_EN) |=> $stable(regs_q));

    // R2: a mode write lands the addressed field in the next cycle
    assert_mode_field_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == A_MODE) |=> (mode_o[0] == $past(wdata_i[XTU_MODE_W-1:0])));

endmodule

// File: rtl/xtu_detect.sv
module xtu_detect
    import xtu_pkg::*;
#(
    parameter int unsigned N_SRC = 6
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [N_SRC-1:0]       lvl_i,
    input  trig_mode_e [N_SRC-1:0] mode_i,
    input  logic [N_SRC-1:0]       en_i,
    input  logic [N_SRC-1:0]       clr_i,
    output logic [N_SRC-1:0]       pend_o,
    output logic [N_SRC-1:0]       req_o
);

    typedef struct packed {
        logic [N_SRC-1:0] prev;
        logic [N_SRC-1:0] pend;
    } det_t;

    det_t det_d, det_q;
    logic [N_SRC-1:0] req_d;

    always_comb begin
        det_d      = det_q;
        det_d.prev = lvl_i;
        req_d      = '0;
        for (int i = 0; i < int'(N_SRC); i++) begin
            logic up, down, hit;
            up   = lvl_i[i] & ~det_q.prev[i];
            down = ~lvl_i[i] & det_q.prev[i];
            unique case (mode_i[i])
                TRIG_RISE: hit = up;
                TRIG_FALL: hit = down;
                TRIG_BOTH: hit = up | down;
                default:   hit = 1'b0;
            endcase
            // a fresh edge wins over a clear in the same cycle
            det_d.pend[i] = hit | (det_q.pend[i] & ~clr_i[i]);
            unique case (mode_i[i])
                TRIG_RISE, TRIG_FALL, TRIG_BOTH: req_d[i] = det_q.pend[i];
                TRIG_HIGH:                        req_d[i] = lvl_i[i];
                TRIG_LOW:                         req_d[i] = ~lvl_i[i];
                default:                          req_d[i] = 1'b0;
            endcase
            req_d[i] = req_d[i] & en_i[i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) det_q <= '0;
        else         det_q <= det_d;
    end

    assign pend_o = det_q.pend;
    assign req_o  = req_d;

    for (genvar g = 0; g < int'(N_SRC); g++) begin : g_chk
        // R10: a disabled pin never requests
        assert_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_i[g] |-> !req_o[g]);
        // R11: pending holds until a clear arrives
        assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (det_q.pend[g] && !clr_i[g]) |=> det_q.pend[g]);
        // R11: a clear with no edge empties the bit
        assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[g] && (lvl_i[g] == det_q.prev[g])) |=> !det_q.pend[g]);
        // R12: in both-edge mode any transition sets pending, clear or not
        assert_edge_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i[g] == TRIG_BOTH && (lvl_i[g] != det_q.prev[g])) |=> det_q.pend[g]);
        // R7 R8 R9: non-edge modes never raise pending
        assert_no_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!mode_is_edge(mode_i[g]) && !det_q.pend[g]) |=> !det_q.pend[g]);
    end

endmodule

// File: rtl/xtu_top.sv
module xtu_top
    import xtu_pkg::*;
#(
    parameter int unsigned N_SRC  = XTU_MAX_SRC,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_SRC-1:0]  pin_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [N_SRC-1:0]  irq_req_o
);

    logic [N_SRC-1:0]       lvl;
    logic [N_SRC-1:0]       pend;
    logic [N_SRC-1:0]       en;
    logic [N_SRC-1:0]       clr;
    trig_mode_e [N_SRC-1:0] mode;

    xtu_sync #(.WIDTH(N_SRC)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_i),
        .q_o    (lvl)
    );

    xtu_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .lvl_i   (lvl),
        .pend_i  (pend),
        .rdata_o (bus_rdata_o),
        .mode_o  (mode),
        .en_o    (en),
        .clr_o   (clr)
    );

    xtu_detect #(.N_SRC(N_SRC)) u_detect (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (lvl),
        .mode_i (mode),
        .en_i   (en),
        .clr_i  (clr),
        .pend_o (pend),
        .req_o  (irq_req_o)
    );

    // cycles since reset, for the synchroniser latency check only
    logic [1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R1: captured level is the pin two edges earlier
    assert_sync_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2) |-> (lvl == $past(pin_i, 2)));

endmodule

// File: tb/xtu_top_tb_top.sv
module xtu_top_tb_top;

    localparam int N  = 6;
    localparam int NV = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] pins = '0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [N-1:0] req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xtu_top dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_i       (pins),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_req_o   (req)
    );

    // {mode[11:9], en[8], pin_before[7], pin_after[6], exp_req[5], exp_pend[4], req_no[3:0]}
    localparam logic [11:0] VEC [NV] = '{
        {3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd4},   // R4 rising seen
        {3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},   // R4 falling ignored
        {3'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd5},   // R5 falling seen
        {3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},   // R5 rising ignored
        {3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd6},   // R6 up
        {3'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd6},   // R6 down
        {3'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7},   // R7 high
        {3'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},   // R7 low
        {3'd6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8},   // R8 low active
        {3'd6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8},   // R8 high idle
        {3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9},   // R9 code 0
        {3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},   // R9 code 4
        {3'd7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9},   // R9 code 7
        {3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd10},  // R10 latched but gated
        {3'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10}   // R10 level gated
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R3 reset state
        bus_read(4'h0, rd); chk("R3 mode word", rd, 32'h0066_6666);
        bus_read(4'hC, rd); chk("R3 enable", rd, 32'h0);
        bus_read(4'h8, rd); chk("R3 pending", rd, 32'h0);
        chk("R3 requests", {26'h0, req}, 32'h0);

        // R1 synchroniser latency
        pins = 6'b101101;
        tick(1);
        bus_read(4'h4, rd); chk("R1 after one edge", rd, 32'h0);
        tick(1);
        bus_read(4'h4, rd); chk("R1 after two edges", rd, 32'h2D);
        pins = '0;
        tick(3);

        // R2 field packing
        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h0, rd); chk("R2 spare bits zero", rd, 32'h0077_7777);
        bus_write(4'h0, 32'h0054_3210);
        bus_read(4'h0, rd); chk("R2 field readback", rd, 32'h0054_3210);

        // table walk over modes
        for (int v = 0; v < NV; v++) begin
            int s;
            logic [11:0] e;
            string tag;
            e = VEC[v];
            s = v % N;
            tag = $sformatf("R%0d vec%0d", e[3:0], v);
            bus_write(4'h0, 32'(e[11:9]) << (4 * s));
            bus_write(4'hC, 32'(e[8]) << s);
            pins = '0;
            pins[s] = e[7];
            tick(4);
            bus_write(4'h8, 32'h0);
            pins[s] = e[6];
            tick(4);
            chk({tag, " request"}, {31'h0, req[s]}, {31'h0, e[5]});
            bus_read(4'h8, rd);
            chk({tag, " pending"}, {31'h0, rd[s]}, {31'h0, e[4]});
        end

        // R10 late enable exposes latched bit
        bus_write(4'h0, 32'h1);
        bus_write(4'hC, 32'h0);
        pins = '0;
        tick(4);
        bus_write(4'h8, 32'h0);
        pins[0] = 1'b1;
        tick(4);
        chk("R10 gated before enable", {26'h0, req}, 32'h0);
        bus_write(4'hC, 32'h1);
        chk("R10 visible after enable", {26'h0, req}, 32'h1);

        // R11 selective clear
        bus_write(4'h0, 32'h11);
        bus_write(4'hC, 32'h3);
        pins = '0;
        tick(4);
        bus_write(4'h8, 32'h0);
        pins = 6'b000011;
        tick(4);
        bus_read(4'h8, rd); chk("R11 both latched", rd, 32'h3);
        bus_write(4'h8, 32'hFFFF_FFFE);
        bus_read(4'h8, rd); chk("R11 only pin0 cleared", rd, 32'h2);
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_read(4'h8, rd); chk("R11 ones keep bits", rd, 32'h2);
        chk("R11 request follows", {26'h0, req}, 32'h2);

        // R12 edge and clear in the same clock
        bus_write(4'h0, 32'h300);
        bus_write(4'hC, 32'h4);
        pins = '0;
        tick(4);
        bus_write(4'h8, 32'h0);
        bus_read(4'h8, rd); chk("R12 start empty", rd, 32'h0);
        pins[2] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr = 1'b1; addr = 4'h8; wdata = 32'h0;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
        bus_read(4'h8, rd); chk("R12 edge beats clear", rd, 32'h4);
        bus_write(4'h8, 32'h0);
        bus_read(4'h8, rd); chk("R12 later clear works", rd, 32'h0);

        // R13 ignored writes
        bus_write(4'h0, 32'h0012_3456);
        bus_write(4'hC, 32'h15);
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_write(4'h1, 32'hFFFF_FFFF);
        bus_write(4'h6, 32'h0);
        bus_read(4'h0, rd); chk("R13 mode untouched", rd, 32'h0012_3456);
        bus_read(4'hC, rd); chk("R13 enable untouched", rd, 32'h15);
        bus_read(4'h4, rd); chk("R13 capture still pins", rd, 32'h4);
        bus_read(4'h2, rd); chk("R13 unmapped reads zero", rd, 32'h0);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule